// File: doc/BRIEF.md
# Program Register Bank with Port Selection

This block keeps the eight 32-bit general registers of a simple one-instruction-per-cycle processor and also decides, from the instruction being decoded, which registers it reads and writes. Each cycle it receives an operation class and two 4-bit register fields taken from the instruction, called the first field and the second field. From these it derives two read addresses and two write addresses. A read address selects a register value that appears on one of the two read outputs in the same cycle. A write address selects the register that takes one of two externally supplied results at the next rising clock edge.

One write port carries the arithmetic result and the other carries the value loaded from memory, so a single instruction such as a stack pop can update two registers at once. Stack operations use register 4, the stack pointer, without naming it in the instruction. Any port the instruction does not need is given the reserved address 8, and a port with address 8 or higher performs no access.

Operation class encoding used throughout: 0 halt, 1 no-op, 2 register-to-register move, 3 immediate-to-register move, 4 register-to-memory store, 5 memory-to-register load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop. The values 12 to 15 select no port.

Top module: `rfdec_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every register reads back as zero.
- R2: Read address X equals the first field for classes 2, 4, 6 and 10. It is 4 for classes 9 and 11, and 8 for every other class.
- R3: Read address Y equals the second field for classes 4, 5 and 6. It is 4 for classes 8, 9, 10 and 11, and 8 for every other class.
- R4: The arithmetic write address equals the second field for classes 2, 3 and 6. It is 4 for classes 8, 9, 10 and 11, and 8 for every other class.
- R5: The memory write address equals the first field for classes 5 and 11, and is 8 for every other class.
- R6: Each read output shows, in the same cycle, the current content of the register its address selects. It shows zero when that address is 8 or higher.
- R7: A write port whose address is below 8 loads its data into that register at the next rising clock edge. The change is not visible before that edge.
- R8: A pop (class 11) writes the arithmetic result into register 4 and the memory result into the register named by the first field, both at the same edge.
- R9: When both write addresses name the same register in one cycle, the memory result is stored.
- R10: A write address of 8 or higher leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opClass | input | 4 | Operation class of the instruction being decoded |
| regFirst | input | 4 | First register field of the instruction |
| regSecond | input | 4 | Second register field of the instruction |
| aluResult | input | 32 | Data for the arithmetic write port |
| memResult | input | 32 | Data for the memory write port |
| readAddrX | output | 4 | Derived address of read port X |
| readAddrY | output | 4 | Derived address of read port Y |
| wrAluAddr | output | 4 | Derived address of the arithmetic write port |
| wrMemAddr | output | 4 | Derived address of the memory write port |
| readDataX | output | 32 | Register value selected by read port X |
| readDataY | output | 32 | Register value selected by read port Y |

## Verification
The four derived addresses and the two read values are combinational. They are due in the same cycle the instruction fields are applied. A write becomes visible only on reads made after the following rising edge. The bench therefore drives the inputs just after a falling edge and compares every output a short delay later, still before the next rising edge. It then applies that cycle's writes to its behavioural register model, and the model is next compared one cycle later. Collisions between the two write ports, out-of-range fields and pops through the stack pointer are driven on purpose, in addition to a long stream of random instructions.

// File: rtl/rfdec_pkg.sv
package rfdec_pkg;
  localparam int RF_NUM_REGS = 8;
  localparam int RF_IDX_W    = $clog2(RF_NUM_REGS);
  localparam int RF_ID_W     = RF_IDX_W + 1;
  localparam int RF_DATA_W   = 32;
  localparam int RF_SP_INDEX = 4;

  typedef logic [RF_ID_W-1:0]   regId_t;
  typedef logic [RF_DATA_W-1:0] word_t;

  localparam regId_t RF_NONE = regId_t'(RF_NUM_REGS);
  localparam regId_t RF_SP   = regId_t'(RF_SP_INDEX);

  typedef enum logic [3:0] {
    OP_HALT    = 4'd0,
    OP_NOP     = 4'd1,
    OP_MOVE_RR = 4'd2,
    OP_MOVE_IR = 4'd3,
    OP_STORE   = 4'd4,
    OP_LOAD    = 4'd5,
    OP_ARITH   = 4'd6,
    OP_JUMP    = 4'd7,
    OP_CALL    = 4'd8,
    OP_RETURN  = 4'd9,
    OP_PUSH    = 4'd10,
    OP_POP     = 4'd11
  } opClass_t;

  // Strobes from port selection to the register bank
  typedef struct packed {
    regId_t rdX;
    regId_t rdY;
    regId_t wrAlu;
    regId_t wrMem;
    logic   wrAluEn;
    logic   wrMemEn;
  } rfStrobes_t;
endpackage

// File: rtl/rfdec_ctrl.sv
module rfdec_ctrl
  import rfdec_pkg::*;
(
  input  logic [3:0]  opClass,
  input  regId_t      regFirst,
  input  regId_t      regSecond,
  output rfStrobes_t  strobes
);
  regId_t selX, selY, selAlu, selMem;

  always_comb begin
    selX   = RF_NONE;
    selY   = RF_NONE;
    selAlu = RF_NONE;
    selMem = RF_NONE;
    case (opClass)
      OP_MOVE_RR: begin selX = regFirst; selAlu = regSecond; end
      OP_MOVE_IR: begin selAlu = regSecond; end
      OP_STORE:   begin selX = regFirst; selY = regSecond; end
      OP_LOAD:    begin selY = regSecond; selMem = regFirst; end
      OP_ARITH:   begin selX = regFirst; selY = regSecond; selAlu = regSecond; end
      OP_CALL:    begin selY = RF_SP; selAlu = RF_SP; end
      OP_RETURN:  begin selX = RF_SP; selY = RF_SP; selAlu = RF_SP; end
      OP_PUSH:    begin selX = regFirst; selY = RF_SP; selAlu = RF_SP; end
      OP_POP:     begin selX = RF_SP; selY = RF_SP; selAlu = RF_SP; selMem = regFirst; end
      default:    ;
    endcase
  end

  always_comb begin
    strobes.rdX     = selX;
    strobes.rdY     = selY;
    strobes.wrAlu   = selAlu;
    strobes.wrMem   = selMem;
    strobes.wrAluEn = (selAlu < RF_NONE);
    strobes.wrMemEn = (selMem < RF_NONE);
  end
endmodule

// File: rtl/rfdec_datapath.sv
module rfdec_datapath
  import rfdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rfStrobes_t strobes,
  input  word_t      aluData,
  input  word_t      memData,
  output word_t      readX,
  output word_t      readY
);
  word_t regs [RF_NUM_REGS];

  for (genvar i = 0; i < RF_NUM_REGS; i++) begin : g_reg
    logic hitAlu, hitMem;
    assign hitAlu = strobes.wrAluEn && (strobes.wrAlu == regId_t'(i));
    assign hitMem = strobes.wrMemEn && (strobes.wrMem == regId_t'(i));

    // Memory port has priority on a shared target
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[i] <= '0;
      else if (hitMem) regs[i] <= memData;
      else if (hitAlu) regs[i] <= aluData;
    end
  end

  function automatic word_t pick(input regId_t id);
    if (id < RF_NONE) return regs[id[RF_IDX_W-1:0]];
    return '0;
  endfunction

  always_comb begin
    readX = pick(strobes.rdX);
    readY = pick(strobes.rdY);
  end
endmodule

// File: rtl/rfdec_top.sv
module rfdec_top
  import rfdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opClass,
  input  logic [3:0]  regFirst,
  input  logic [3:0]  regSecond,
  input  logic [31:0] aluResult,
  input  logic [31:0] memResult,
  output logic [3:0]  readAddrX,
  output logic [3:0]  readAddrY,
  output logic [3:0]  wrAluAddr,
  output logic [3:0]  wrMemAddr,
  output logic [31:0] readDataX,
  output logic [31:0] readDataY
);
  rfStrobes_t strobes;

  rfdec_ctrl u_ctrl (
    .opClass   (opClass),
    .regFirst  (regFirst),
    .regSecond (regSecond),
    .strobes   (strobes)
  );

  rfdec_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .aluData (aluResult),
    .memData (memResult),
    .readX   (readDataX),
    .readY   (readDataY)
  );

  assign readAddrX = strobes.rdX;
  assign readAddrY = strobes.rdY;
  assign wrAluAddr = strobes.wrAlu;
  assign wrMemAddr = strobes.wrMem;
endmodule

// File: rtl/rfdec_checker.sv
module rfdec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  opClass,
  input logic [3:0]  regFirst,
  input logic [31:0] aluResult,
  input logic [31:0] memResult,
  input logic [3:0]  readAddrX,
  input logic [3:0]  readAddrY,
  input logic [3:0]  wrAluAddr,
  input logic [3:0]  wrMemAddr,
  input logic [31:0] readDataX,
  input logic [31:0] readDataY
);
  localparam logic [3:0] NONE = 4'd8;
  localparam logic [3:0] SP   = 4'd4;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (readDataX == 32'd0 && readDataY == 32'd0));

  assert_pop_read_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opClass == 4'd11) |-> (readAddrX == SP));

  assert_call_read_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opClass == 4'd8) |-> (readAddrY == SP && readAddrX == NONE));

  assert_store_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opClass == 4'd4) |-> (wrAluAddr == NONE && wrMemAddr == NONE));

  assert_mem_port_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opClass != 4'd5 && opClass != 4'd11) |-> (wrMemAddr == NONE));

  assert_out_of_range_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (readAddrX >= NONE) |-> (readDataX == 32'd0));

  assert_alu_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAluAddr < NONE && wrAluAddr != wrMemAddr) |=>
      (readAddrY != $past(wrAluAddr) || readDataY == $past(aluResult)));

  assert_pop_dual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opClass == 4'd11) |-> (wrAluAddr == SP && wrMemAddr == regFirst));

  assert_mem_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrMemAddr < NONE) |=>
      (readAddrX != $past(wrMemAddr) || readDataX == $past(memResult)));

  assert_no_write_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAluAddr >= NONE && wrMemAddr >= NONE) |=>
      (readAddrX != $past(readAddrX) || $stable(readDataX)));
endmodule

bind rfdec_top rfdec_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opClass   (opClass),
  .regFirst  (regFirst),
  .aluResult (aluResult),
  .memResult (memResult),
  .readAddrX (readAddrX),
  .readAddrY (readAddrY),
  .wrAluAddr (wrAluAddr),
  .wrMemAddr (wrMemAddr),
  .readDataX (readDataX),
  .readDataY (readDataY)
);

// File: tb/rfdec_top_test.sv
module rfdec_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opClass = 4'd0;
  logic [3:0]  regFirst = 4'd0;
  logic [3:0]  regSecond = 4'd0;
  logic [31:0] aluResult = 32'd0;
  logic [31:0] memResult = 32'd0;
  logic [3:0]  readAddrX, readAddrY, wrAluAddr, wrMemAddr;
  logic [31:0] readDataX, readDataY;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  rfdec_top uut (
    .clk(clk), .rst_n(rst_n), .opClass(opClass), .regFirst(regFirst),
    .regSecond(regSecond), .aluResult(aluResult), .memResult(memResult),
    .readAddrX(readAddrX), .readAddrY(readAddrY), .wrAluAddr(wrAluAddr),
    .wrMemAddr(wrMemAddr), .readDataX(readDataX), .readDataY(readDataY)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'd0;
  endfunction

  // One instruction: drive after falling edge, compare, then apply writes to the model
  task automatic step(input string tag, input int op, input int a, input int b,
                      input logic [31:0] alu, input logic [31:0] mem);
    logic [3:0] ex, ey, ea, em;
    @(negedge clk);
    opClass = 4'(op); regFirst = 4'(a); regSecond = 4'(b);
    aluResult = alu; memResult = mem;
    #1;
    ex = 4'd8; ey = 4'd8; ea = 4'd8; em = 4'd8;
    case (op)
      2:  begin ex = 4'(a); ea = 4'(b); end
      3:  ea = 4'(b);
      4:  begin ex = 4'(a); ey = 4'(b); end
      5:  begin ey = 4'(b); em = 4'(a); end
      6:  begin ex = 4'(a); ey = 4'(b); ea = 4'(b); end
      8:  begin ey = 4'd4; ea = 4'd4; end
      9:  begin ex = 4'd4; ey = 4'd4; ea = 4'd4; end
      10: begin ex = 4'(a); ey = 4'd4; ea = 4'd4; end
      11: begin ex = 4'd4; ey = 4'd4; ea = 4'd4; em = 4'(a); end
      default: ;
    endcase
    check({tag, " R2 addrX"}, 32'(readAddrX), 32'(ex));
    check({tag, " R3 addrY"}, 32'(readAddrY), 32'(ey));
    check({tag, " R4 addrAlu"}, 32'(wrAluAddr), 32'(ea));
    check({tag, " R5 addrMem"}, 32'(wrMemAddr), 32'(em));
    check({tag, " R6 dataX"}, readDataX, expRead(ex));
    check({tag, " R6 dataY"}, readDataY, expRead(ey));
    if (ea < 4'd8) model[ea[2:0]] = alu;
    if (em < 4'd8) model[em[2:0]] = mem;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    // R1: reads during reset are zero
    opClass = 4'd4; regFirst = 4'd3; regSecond = 4'd7;
    #1;
    check("R1 reset X", readDataX, 32'd0);
    check("R1 reset Y", readDataY, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step("R1 post-reset", 4, i, (i + 1) % 8, 32'd0, 32'd0);

    // R7: immediate move writes, visible only after the edge
    step("R7 write", 3, 0, 5, 32'hA5A5_0001, 32'hFFFF_FFFF);
    step("R7 readback", 4, 5, 5, 32'd0, 32'd0);
    // R8: pop writes stack pointer and target together
    step("R8 seed sp", 3, 0, 4, 32'h0000_1000, 32'd0);
    step("R8 pop", 11, 2, 0, 32'h0000_1004, 32'hDEAD_BEEF);
    step("R8 check", 4, 2, 4, 32'd0, 32'd0);
    // R9: pop into the stack pointer, memory value wins
    step("R9 collide", 11, 4, 0, 32'h1111_1111, 32'h2222_2222);
    step("R9 check", 4, 4, 4, 32'd0, 32'd0);
    // R9: load into the register the ALU port also targets is impossible by class, so repeat with load
    step("R9 load", 5, 6, 1, 32'd0, 32'h3333_4444);
    step("R9 load check", 4, 6, 6, 32'd0, 32'd0);
    // R10: out-of-range targets leave registers unchanged
    step("R10 imm 12", 3, 0, 12, 32'h5555_5555, 32'd0);
    step("R10 load 9", 5, 9, 0, 32'd0, 32'h6666_6666);
    for (int i = 0; i < 8; i += 2) step("R10 scan", 4, i, i + 1, 32'd0, 32'd0);
    // R6: out-of-range read fields
    step("R6 oob read", 6, 13, 15, 32'h7777_0000, 32'd0);
    // Random instruction stream
    for (int n = 0; n < 2000; n++)
      step("rand", int'($urandom_range(15)), int'($urandom_range(15)),
           int'($urandom_range(15)), $urandom, $urandom);
    for (int i = 0; i < 8; i++) step("final scan", 2, i, 8, 32'd0, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule